// File: doc/BRIEF.md
# Controller Configuration and Status Registers

This block holds the configuration word, the status word, the admin queue sizes and the two 64-bit admin queue base addresses of a storage controller. Software reaches these registers over a simple 32-bit register bus. Each register write is masked to its writable bits.

Changes to the enable bit and to the shutdown field are detected by comparing the written value with the configuration word held before the write. Those changes drive one-cycle requests to the command datapath: start, stop, quiesce, and reset of the interrupt state. When the datapath reports whether start-up succeeded, the block records the result in the status word.

Disabling the controller wipes the configuration and status words. The admin queue setup is kept, so software can re-enable without programming it again. A shutdown request leaves the configuration alone, quiesces the datapath and reports completion in the status word.

Top module: `ctrl_cfg_regs`

## Requirements
- R1: After reset, every register reads zero and none of the start, stop, quiesce or interrupt-reset requests is asserted.
- R2: A write to offset 0x14 stores the data ANDed with 0x00FFFFF1. The enable bit is bit 0 and the shutdown field is bits 15:14.
- R3: A write to offset 0x24 stores the data ANDed with 0x0FFF0FFF.
- R4: The submission base is 64 bits, with its low half at 0x28 and high half at 0x2C. The completion base is likewise split across 0x30 and 0x34. Bits 11:0 of each base always read zero, and a write to one half leaves the other half unchanged.
- R5: A configuration write that changes the enable bit from 0 to 1 raises start_req for exactly one cycle, in the cycle after the write. A write that leaves the enable bit at 1 raises no start request.
- R6: start_done is accepted only while a start is outstanding. When accepted, the status word shows ready (bit 0) = start_ok and fatal (bit 1) = !start_ok from the next cycle. A start_done with nothing outstanding changes nothing.
- R7: A configuration write that changes the enable bit from 1 to 0 does the following:
  - clears the configuration and status words;
  - pulses stop_req and irq_reset for one cycle;
  - cancels any outstanding start, so a later start_done is ignored;
  - leaves the admin queue registers unchanged.
- R8: A configuration write that changes the shutdown field from zero to nonzero pulses quiesce_req and sets the shutdown status (bits 3:2) to 2'b10. The configuration word and the ready bit are kept.
- R9: A configuration write that changes the shutdown field from nonzero to zero returns the shutdown status to 2'b00 without a quiesce request.
- R10: A single write that both clears the enable bit and sets the shutdown field leaves the configuration word at zero and the status word at exactly 0x00000008.
- R11: Writes to the status offset 0x1C have no effect. Reads of unmapped offsets return zero.
- R12: Read data appears on rdata in the cycle after rd_en and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| start_done | input | 1 | Datapath start attempt finished |
| start_ok | input | 1 | Start attempt succeeded (valid with start_done) |
| start_req | output | 1 | One-cycle request to start the datapath |
| stop_req | output | 1 | One-cycle request to stop and reset the datapath |
| quiesce_req | output | 1 | One-cycle request to quiesce for shutdown |
| irq_reset | output | 1 | One-cycle request to clear interrupt masks and pending interrupts |
| cc_q | output | 32 | Current configuration word |
| csts_q | output | 32 | Current status word |
| aqa_q | output | 32 | Admin queue size word |
| asq_q | output | BASE_W | Admin submission queue base |
| acq_q | output | BASE_W | Admin completion queue base |

## Verification
The bench builds the block with ADDR_W = 8 and BASE_W = 64. With those values every offset from 0x14 to 0x34 is decodable, and an unmapped offset such as 0x40 is also reachable. Both 32-bit halves of each base are exercised as well.

The bench's datapath responder answers each start request after three cycles. That gap leaves room to disable the controller while a start is still outstanding, and to inject a start result when no start is outstanding. It also allows enable, shutdown and disable transitions to be combined in a single write.

// File: rtl/ccfg_pkg.sv
package ccfg_pkg;

    localparam int REG_W = 32;

    localparam logic [7:0] OFF_CC     = 8'h14;
    localparam logic [7:0] OFF_CSTS   = 8'h1C;
    localparam logic [7:0] OFF_AQA    = 8'h24;
    localparam logic [7:0] OFF_ASQ_LO = 8'h28;
    localparam logic [7:0] OFF_ASQ_HI = 8'h2C;
    localparam logic [7:0] OFF_ACQ_LO = 8'h30;
    localparam logic [7:0] OFF_ACQ_HI = 8'h34;

    localparam logic [REG_W-1:0] CC_WMASK  = 32'h00FF_FFF1;
    localparam logic [REG_W-1:0] AQA_WMASK = 32'h0FFF_0FFF;

    typedef enum logic [1:0] {
        SHST_IDLE = 2'b00,
        SHST_BUSY = 2'b01,
        SHST_DONE = 2'b10
    } shst_e;

    typedef struct packed {
        logic [27:0] rsvd;
        shst_e       shst;
        logic        fatal;
        logic        ready;
    } csts_t;

    typedef struct packed {
        logic cc;
        logic csts;
        logic aqa;
        logic asq_lo;
        logic asq_hi;
        logic acq_lo;
        logic acq_hi;
    } sel_t;

    function automatic logic cc_enable(input logic [REG_W-1:0] v);
        return v[0];
    endfunction

    function automatic logic [1:0] cc_shutdown(input logic [REG_W-1:0] v);
        return v[15:14];
    endfunction

endpackage

// File: rtl/ccfg_decode.sv
module ccfg_decode
    import ccfg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_t              sel
);
    always_comb begin
        sel        = '0;
        sel.cc     = (addr == ADDR_W'(OFF_CC));
        sel.csts   = (addr == ADDR_W'(OFF_CSTS));
        sel.aqa    = (addr == ADDR_W'(OFF_AQA));
        sel.asq_lo = (addr == ADDR_W'(OFF_ASQ_LO));
        sel.asq_hi = (addr == ADDR_W'(OFF_ASQ_HI));
        sel.acq_lo = (addr == ADDR_W'(OFF_ACQ_LO));
        sel.acq_hi = (addr == ADDR_W'(OFF_ACQ_HI));
    end
endmodule

// File: rtl/ccfg_adminq.sv
module ccfg_adminq
    import ccfg_pkg::*;
#(
    parameter int BASE_W     = 64,
    parameter int ALIGN_BITS = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  sel_t              sel,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  aqa_q,
    output logic [BASE_W-1:0] asq_q,
    output logic [BASE_W-1:0] acq_q
);
    localparam int HI_W = BASE_W - REG_W;
    localparam logic [REG_W-1:0] LO_MASK = ~((REG_W'(1) << ALIGN_BITS) - REG_W'(1));

    logic [1:0]             lo_wr;
    logic [1:0]             hi_wr;
    logic [1:0][BASE_W-1:0] base_q;

    assign lo_wr = {sel.acq_lo, sel.asq_lo} & {2{wr_en}};
    assign hi_wr = {sel.acq_hi, sel.asq_hi} & {2{wr_en}};

    always_ff @(posedge clk) begin
        if (rst) begin
            aqa_q <= '0;
        end else if (wr_en && sel.aqa) begin
            aqa_q <= wdata & AQA_WMASK;
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_base
        logic [REG_W-1:0] lo_q;
        logic [HI_W-1:0]  hi_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                lo_q <= '0;
                hi_q <= '0;
            end else begin
                if (lo_wr[g]) lo_q <= wdata & LO_MASK;
                if (hi_wr[g]) hi_q <= wdata[HI_W-1:0];
            end
        end
        assign base_q[g] = {hi_q, lo_q};
    end

    assign asq_q = base_q[0];
    assign acq_q = base_q[1];
endmodule

// File: rtl/ccfg_ctrl.sv
module ccfg_ctrl
    import ccfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_cc,
    input  logic [REG_W-1:0] wdata,
    input  logic             start_done,
    input  logic             start_ok,
    output logic [REG_W-1:0] cc_q,
    output csts_t            csts_q,
    output logic             start_req,
    output logic             stop_req,
    output logic             quiesce_req,
    output logic             irq_reset
);
    logic             pend_q;
    logic             pend_n;
    logic [REG_W-1:0] cc_n;
    csts_t            csts_n;
    logic             start_n;
    logic             stop_n;
    logic             quiesce_n;
    logic [REG_W-1:0] cc_new;
    logic             en_rise;
    logic             en_fall;
    logic             shn_set;
    logic             shn_clr;

    assign cc_new  = wdata & CC_WMASK;
    assign en_rise = wr_cc &&  cc_enable(cc_new) && !cc_enable(cc_q);
    assign en_fall = wr_cc && !cc_enable(cc_new) &&  cc_enable(cc_q);
    assign shn_set = wr_cc && (cc_shutdown(cc_new) != 2'b00) && (cc_shutdown(cc_q) == 2'b00);
    assign shn_clr = wr_cc && (cc_shutdown(cc_new) == 2'b00) && (cc_shutdown(cc_q) != 2'b00);

    always_comb begin
        cc_n      = cc_q;
        csts_n    = csts_q;
        pend_n    = pend_q;
        start_n   = 1'b0;
        stop_n    = 1'b0;
        quiesce_n = 1'b0;

        // start result first, so a same-cycle disable overrides it
        if (start_done && pend_q) begin
            csts_n.ready = start_ok;
            csts_n.fatal = !start_ok;
            pend_n       = 1'b0;
        end

        if (wr_cc) begin
            cc_n = cc_new;
        end

        if (en_rise) begin
            start_n = 1'b1;
            pend_n  = 1'b1;
        end else if (en_fall) begin
            cc_n   = '0;
            csts_n = '0;
            stop_n = 1'b1;
            pend_n = 1'b0;
        end

        if (shn_set) begin
            quiesce_n   = 1'b1;
            csts_n.shst = SHST_DONE;
        end else if (shn_clr) begin
            csts_n.shst = SHST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cc_q        <= '0;
            csts_q      <= '0;
            pend_q      <= 1'b0;
            start_req   <= 1'b0;
            stop_req    <= 1'b0;
            quiesce_req <= 1'b0;
            irq_reset   <= 1'b0;
        end else begin
            cc_q        <= cc_n;
            csts_q      <= csts_n;
            pend_q      <= pend_n;
            start_req   <= start_n;
            stop_req    <= stop_n;
            quiesce_req <= quiesce_n;
            irq_reset   <= stop_n;
        end
    end
endmodule

// File: rtl/ctrl_cfg_regs.sv
module ctrl_cfg_regs
    import ccfg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BASE_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              start_done,
    input  logic              start_ok,
    output logic              start_req,
    output logic              stop_req,
    output logic              quiesce_req,
    output logic              irq_reset,
    output logic [31:0]       cc_q,
    output logic [31:0]       csts_q,
    output logic [31:0]       aqa_q,
    output logic [BASE_W-1:0] asq_q,
    output logic [BASE_W-1:0] acq_q
);
    sel_t             sel;
    csts_t            csts_s;
    logic [REG_W-1:0] rd_mux;

    ccfg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .sel  (sel)
    );

    ccfg_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .wr_cc       (wr_en && sel.cc),
        .wdata       (wdata),
        .start_done  (start_done),
        .start_ok    (start_ok),
        .cc_q        (cc_q),
        .csts_q      (csts_s),
        .start_req   (start_req),
        .stop_req    (stop_req),
        .quiesce_req (quiesce_req),
        .irq_reset   (irq_reset)
    );

    ccfg_adminq #(.BASE_W(BASE_W)) u_aq (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .sel   (sel),
        .wdata (wdata),
        .aqa_q (aqa_q),
        .asq_q (asq_q),
        .acq_q (acq_q)
    );

    assign csts_q = csts_s;

    always_comb begin
        rd_mux = '0;
        unique case (1'b1)
            sel.cc:     rd_mux = cc_q;
            sel.csts:   rd_mux = csts_s;
            sel.aqa:    rd_mux = aqa_q;
            sel.asq_lo: rd_mux = asq_q[REG_W-1:0];
            sel.asq_hi: rd_mux = REG_W'(asq_q >> REG_W);
            sel.acq_lo: rd_mux = acq_q[REG_W-1:0];
            sel.acq_hi: rd_mux = REG_W'(acq_q >> REG_W);
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/ccfg_checker.sv
module ccfg_checker #(
    parameter int BASE_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              start_done,
    input logic              start_ok,
    input logic              start_req,
    input logic              stop_req,
    input logic              quiesce_req,
    input logic              irq_reset,
    input logic [31:0]       cc_q,
    input logic [31:0]       csts_q,
    input logic [31:0]       aqa_q,
    input logic [BASE_W-1:0] asq_q,
    input logic [BASE_W-1:0] acq_q
);
    assert_start_single_R5: assert property (@(posedge clk) disable iff (rst)
        start_req |=> !start_req);

    assert_start_from_enable_R5: assert property (@(posedge clk) disable iff (rst)
        start_req |-> (cc_q[0] && !$past(cc_q[0])));

    assert_ready_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(csts_q[0]) |-> $past(start_done && start_ok));

    assert_disable_clears_R7: assert property (@(posedge clk) disable iff (rst)
        stop_req |-> (cc_q == 32'h0 && csts_q[1:0] == 2'b00 && irq_reset));

    assert_adminq_kept_R7: assert property (@(posedge clk) disable iff (rst)
        stop_req |-> ($stable(aqa_q) && $stable(asq_q) && $stable(acq_q)));

    assert_shutdown_done_R8: assert property (@(posedge clk) disable iff (rst)
        quiesce_req |-> (csts_q[3:2] == 2'b10));
endmodule

bind ctrl_cfg_regs ccfg_checker #(.BASE_W(BASE_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .start_done  (start_done),
    .start_ok    (start_ok),
    .start_req   (start_req),
    .stop_req    (stop_req),
    .quiesce_req (quiesce_req),
    .irq_reset   (irq_reset),
    .cc_q        (cc_q),
    .csts_q      (csts_q),
    .aqa_q       (aqa_q),
    .asq_q       (asq_q),
    .acq_q       (acq_q)
);

// File: tb/ctrl_cfg_regs_tb.sv
module ctrl_cfg_regs_tb_top;
    localparam int ADDR_W = 8;
    localparam int BASE_W = 64;
    localparam int LAT    = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              start_done = 1'b0;
    logic              start_ok = 1'b0;
    logic              start_req, stop_req, quiesce_req, irq_reset;
    logic [31:0]       cc_q, csts_q, aqa_q;
    logic [BASE_W-1:0] asq_q, acq_q;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // responder controls
    bit ok_sel = 1'b1;
    int inj_req = 0;
    int inj_ack = 0;
    int n_start = 0;
    int cnt = 0;

    // reference model state
    logic [31:0] m_cc, m_csts, m_aqa, m_rdata;
    logic [63:0] m_asq, m_acq;
    bit m_pend, m_start, m_stop, m_quies;

    always #2 clk = ~clk;

    ctrl_cfg_regs #(.ADDR_W(ADDR_W), .BASE_W(BASE_W)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .start_done(start_done), .start_ok(start_ok),
        .start_req(start_req), .stop_req(stop_req), .quiesce_req(quiesce_req),
        .irq_reset(irq_reset), .cc_q(cc_q), .csts_q(csts_q), .aqa_q(aqa_q),
        .asq_q(asq_q), .acq_q(acq_q)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // reference model, driven by the requirements
    always @(posedge clk) begin
        logic [31:0] prev, nw;
        if (rst) begin
            m_cc = 0; m_csts = 0; m_aqa = 0; m_asq = 0; m_acq = 0; m_rdata = 0;
            m_pend = 0; m_start = 0; m_stop = 0; m_quies = 0;
        end else begin
            m_start = 0; m_stop = 0; m_quies = 0;
            if (rd_en) begin
                case (addr)
                    8'h14: m_rdata = m_cc;
                    8'h1C: m_rdata = m_csts;
                    8'h24: m_rdata = m_aqa;
                    8'h28: m_rdata = m_asq[31:0];
                    8'h2C: m_rdata = m_asq[63:32];
                    8'h30: m_rdata = m_acq[31:0];
                    8'h34: m_rdata = m_acq[63:32];
                    default: m_rdata = 0;
                endcase
            end
            if (start_done && m_pend) begin
                m_csts[0] = start_ok;
                m_csts[1] = !start_ok;
                m_pend = 0;
            end
            if (wr_en) begin
                case (addr)
                    8'h14: begin
                        prev = m_cc;
                        nw = wdata & 32'h00FFFFF1;
                        m_cc = nw;
                        if (nw[0] && !prev[0]) begin
                            m_start = 1; m_pend = 1;
                        end else if (!nw[0] && prev[0]) begin
                            m_cc = 0; m_csts = 0; m_stop = 1; m_pend = 0;
                        end
                        if (nw[15:14] != 0 && prev[15:14] == 0) begin
                            m_quies = 1; m_csts[3:2] = 2'b10;
                        end else if (nw[15:14] == 0 && prev[15:14] != 0) begin
                            m_csts[3:2] = 2'b00;
                        end
                    end
                    8'h24: m_aqa = wdata & 32'h0FFF0FFF;
                    8'h28: m_asq[31:0] = wdata & 32'hFFFFF000;
                    8'h2C: m_asq[63:32] = wdata;
                    8'h30: m_acq[31:0] = wdata & 32'hFFFFF000;
                    8'h34: m_acq[63:32] = wdata;
                    default: ;
                endcase
            end
        end
    end

    // every-cycle comparison against the model
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && !finished) begin
                chk("R2 cc_q", 64'(cc_q), 64'(m_cc));
                chk("R6 csts_q", 64'(csts_q), 64'(m_csts));
                chk("R3 aqa_q", 64'(aqa_q), 64'(m_aqa));
                chk("R4 asq_q", asq_q, m_asq);
                chk("R4 acq_q", acq_q, m_acq);
                chk("R5 start_req", 64'(start_req), 64'(m_start));
                chk("R7 stop_req", 64'(stop_req), 64'(m_stop));
                chk("R7 irq_reset", 64'(irq_reset), 64'(m_stop));
                chk("R8 quiesce_req", 64'(quiesce_req), 64'(m_quies));
                chk("R12 rdata", 64'(rdata), 64'(m_rdata));
            end
        end
    end

    // datapath responder
    initial begin
        forever begin
            @(negedge clk);
            start_done = 1'b0;
            if (inj_req != inj_ack) begin
                start_done = 1'b1;
                start_ok = 1'b1;
                inj_ack = inj_req;
            end else if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    start_done = 1'b1;
                    start_ok = ok_sel;
                end
            end
            if (start_req && !rst) begin
                cnt = LAT;
                n_start++;
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        summary();
    end

    initial begin
        logic [31:0] v;
        int s0;
        idle(3);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd(8'h14, v); chk("R1 cc after reset", 64'(v), 0);
        rd(8'h1C, v); chk("R1 csts after reset", 64'(v), 0);
        rd(8'h2C, v); chk("R1 asq hi after reset", 64'(v), 0);
        chk("R1 no pulses", 64'({start_req, stop_req, quiesce_req, irq_reset}), 0);

        // R2 configuration mask
        wr(8'h14, 32'hFF0F_3FFE);
        rd(8'h14, v); chk("R2 cc masked", 64'(v), 64'h000F_3FF0);

        // R3 queue size mask
        wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h24, v); chk("R3 aqa masked", 64'(v), 64'h0FFF_0FFF);

        // R4 base halves
        wr(8'h28, 32'h1234_5FFF);
        wr(8'h2C, 32'hDEAD_BEEF);
        wr(8'h30, 32'hABCD_E123);
        wr(8'h34, 32'h0000_0001);
        rd(8'h28, v); chk("R4 asq lo aligned", 64'(v), 64'h1234_5000);
        rd(8'h2C, v); chk("R4 asq hi", 64'(v), 64'hDEAD_BEEF);
        wr(8'h34, 32'h0000_0002);
        rd(8'h30, v); chk("R4 acq lo kept", 64'(v), 64'hABCD_E000);
        rd(8'h34, v); chk("R4 acq hi rewritten", 64'(v), 64'h2);

        // R5 / R6 enable with success
        ok_sel = 1'b1;
        s0 = n_start;
        wr(8'h14, 32'h000F_3FF1);
        idle(6);
        chk("R5 one start pulse", 64'(n_start - s0), 1);
        rd(8'h1C, v); chk("R6 ready after start", 64'(v), 64'h1);
        wr(8'h14, 32'h000F_3EF1);
        idle(3);
        chk("R5 no start on 1-to-1", 64'(n_start - s0), 1);

        // R11 status write ignored, unmapped read
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h1C, v); chk("R11 csts unchanged", 64'(v), 64'h1);
        rd(8'h40, v); chk("R11 unmapped reads zero", 64'(v), 0);

        // R8 shutdown
        wr(8'h14, 32'h000F_7FF1);
        rd(8'h1C, v); chk("R8 shutdown complete, ready kept", 64'(v), 64'h9);
        rd(8'h14, v); chk("R8 cc kept", 64'(v), 64'h000F_7FF1);

        // R9 shutdown field cleared
        wr(8'h14, 32'h000F_3FF1);
        rd(8'h1C, v); chk("R9 shutdown status cleared", 64'(v), 64'h1);

        // R7 disable
        wr(8'h14, 32'h000F_3FF0);
        rd(8'h14, v); chk("R7 cc cleared", 64'(v), 0);
        rd(8'h1C, v); chk("R7 csts cleared", 64'(v), 0);
        rd(8'h24, v); chk("R7 aqa kept", 64'(v), 64'h0FFF_0FFF);
        rd(8'h2C, v); chk("R7 asq hi kept", 64'(v), 64'hDEAD_BEEF);

        // R6 failed start
        ok_sel = 1'b0;
        wr(8'h14, 32'h0000_0001);
        idle(6);
        rd(8'h1C, v); chk("R6 fatal on failed start", 64'(v), 64'h2);
        wr(8'h14, 32'h0000_0000);

        // R6 stray start result ignored
        inj_req++;
        idle(4);
        rd(8'h1C, v); chk("R6 stray result ignored", 64'(v), 0);

        // R7 disable cancels outstanding start
        ok_sel = 1'b1;
        wr(8'h14, 32'h0000_0001);
        wr(8'h14, 32'h0000_0000);
        idle(6);
        rd(8'h1C, v); chk("R7 cancelled start ignored", 64'(v), 0);

        // R10 combined disable and shutdown
        wr(8'h14, 32'h000F_3FF1);
        idle(6);
        rd(8'h1C, v); chk("R10 ready before combined write", 64'(v), 64'h1);
        wr(8'h14, 32'h0000_8000);
        rd(8'h14, v); chk("R10 cc zero", 64'(v), 0);
        rd(8'h1C, v); chk("R10 csts shutdown only", 64'(v), 64'h8);

        // R12 rdata holds without a read
        wr(8'h24, 32'h0000_0005);
        idle(2);
        chk("R12 rdata held", 64'(rdata), 64'h8);

        idle(2);
        summary();
    end
endmodule